// File: doc/BRIEF.md
# Barrel Shifter with Carry and Result Flags

This block is the shift stage of a small processor datapath. It takes one 32-bit operand and applies one of four operations to it: logical left, logical right, arithmetic right or rotate right. The distance comes either from the low byte of a register or from a 5-bit field carried in the instruction. Alongside the shifted value it produces the carry-out and the negative and zero flags. Register reads, instruction decode and the flag register are outside the block. The caller passes in the current carry flag so that the block can hand it back unchanged when an operation leaves carry alone.

The block has no clock and no state. The outputs follow the inputs within the same cycle, so the block can sit between a register-read stage and a write-back register. Shift distances of zero, exactly the data width, and more than the data width each have their own fixed result and carry rules. An immediate distance of zero is read differently depending on the operation.

Top module: `shifter_unit`

## Requirements
- R1: With the register source selected (`use_imm_i`=0), the distance is the 8-bit `amt_reg_i`. A distance of zero returns the operand unchanged, and `carry_o` equals `carry_i`, for every kind.
- R2: Kind 2'b00 (logical left) with distance n from 1 to 31 returns the operand shifted left with zeros filled in, and `carry_o` = operand bit 32−n.
- R3: Kind 2'b01 (logical right) with distance n from 1 to 31 returns the operand shifted right with zeros filled in, and `carry_o` = operand bit n−1.
- R4: Kind 2'b10 (arithmetic right) with distance n from 1 to 31 fills with copies of operand bit 31, and `carry_o` = operand bit n−1.
- R5: A logical shift by exactly 32 returns zero. `carry_o` is operand bit 0 for kind 2'b00 and operand bit 31 for kind 2'b01.
- R6: A logical shift (kind 2'b00 or 2'b01) by 33 to 255 returns zero, and `carry_o` is 0.
- R7: Kind 2'b10 with a distance of 32 to 255 returns 32 copies of operand bit 31, and `carry_o` equals operand bit 31.
- R8: Kind 2'b11 (rotate right) uses only distance bits [4:0]. When those bits are nonzero, the result is the operand rotated right by that amount and `carry_o` = operand bit (amount−1). When those bits are zero but the distance is not zero, the operand is returned unchanged and `carry_o` = operand bit 31.
- R9: With the immediate source selected (`use_imm_i`=1), an immediate of zero on kind 2'b00 or kind 2'b11 returns the operand unchanged with `carry_o` = `carry_i`. A nonzero immediate acts as a register distance of the same value.
- R10: An immediate of zero on kind 2'b01 or kind 2'b10 behaves exactly as a shift by 32.
- R11: `neg_o` equals bit 31 of `result_o`, and `zero_o` is 1 exactly when `result_o` is all zeros, for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted |
| amt_reg_i | input | 8 | Low byte of the register that holds the distance |
| amt_imm_i | input | 5 | Distance field taken from the instruction |
| use_imm_i | input | 1 | 1 selects `amt_imm_i`, 0 selects `amt_reg_i` |
| kind_i | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | New carry flag |
| neg_o | output | 1 | Copy of result bit 31 |
| zero_o | output | 1 | Result is zero |

## Verification
The bench targets the distance boundaries of 0, 1, 31, 32, 33 and 255 on all four kinds, where the carry rules change. Three typical faults show up here. A design that clamps distances of 32 and above to a single rule gives the wrong carry on a logical shift by exactly 32. A design that masks rotate distances before testing for zero returns the incoming carry instead of bit 31 on a rotate by 32. A design that passes an immediate zero straight through on right shifts returns the operand instead of zero or the sign fill. Operands with distinct patterns at bits 0, 1 and 31 separate off-by-one errors in which bit the carry is taken from.

// File: rtl/shifter_pkg.sv
// Shared encodings for the shift unit.
package shifter_pkg;

    // Shift kind; the encoding is decoded directly from the instruction field.
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/shift_amount_sel.sv
// Chooses the effective shift distance.
// Assumes DATA_W fits in AMT_W bits. An immediate of zero on a right shift is
// rewritten to DATA_W; on a left shift or a rotate it stays zero (pass-through).
module shift_amount_sel
    import shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 5
) (
    input  logic [1:0]       kind_i,
    input  logic             use_imm_i,
    input  logic [AMT_W-1:0] amt_reg_i,
    input  logic [IMM_W-1:0] amt_imm_i,
    output logic [AMT_W-1:0] amt_o
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic imm_is_zero;
    logic right_kind;

    assign imm_is_zero = (amt_imm_i == '0);
    assign right_kind  = (kind_i == SK_LSR) || (kind_i == SK_ASR);

    // Select the distance source and apply the immediate-zero rewrite.
    always_comb begin
        if (!use_imm_i) begin
            amt_o = amt_reg_i;
        end else if (imm_is_zero && right_kind) begin
            amt_o = FULL_AMT;
        end else begin
            amt_o = {{(AMT_W-IMM_W){1'b0}}, amt_imm_i};
        end
    end

endmodule

// File: rtl/shift_stages.sv
// Logarithmic shifter core with two chains.
// The first chain shifts {din, guard} right, filling with `fill`. Bit 0 of its
// output is the last bit shifted out. The second chain rotates din right.
// Assumes DATA_W is a power of two and dist_i < DATA_W.
module shift_stages #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din_i,
    input  logic              fill_i,
    input  logic [SH_W-1:0]   dist_i,
    output logic [DATA_W:0]   ext_o,
    output logic [DATA_W-1:0] rot_o
);

    logic [DATA_W:0]   ext_s [0:SH_W];
    logic [DATA_W-1:0] rot_s [0:SH_W];

    assign ext_s[0] = {din_i, 1'b0};
    assign rot_s[0] = din_i;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int D = 1 << k;
        // Shift stage k: move by 2**k when the matching distance bit is set.
        assign ext_s[k+1] = dist_i[k] ? {{D{fill_i}}, ext_s[k][DATA_W:D]} : ext_s[k];
        // Rotate stage k: move by 2**k when the matching distance bit is set.
        assign rot_s[k+1] = dist_i[k] ? {rot_s[k][D-1:0], rot_s[k][DATA_W-1:D]} : rot_s[k];
    end

    assign ext_o = ext_s[SH_W];
    assign rot_o = rot_s[SH_W];

endmodule

// File: rtl/shift_result_mux.sv
// Applies the boundary rules for distances of zero, DATA_W and above DATA_W,
// and picks the in-range value from the shifter core.
// For a left shift the core was fed the bit-reversed operand, so the value is
// reversed again here.
module shift_result_mux
    import shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [1:0]        kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    input  logic [DATA_W:0]   ext_i,
    input  logic [DATA_W-1:0] rot_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic              amt_zero;
    logic              amt_full;
    logic              amt_over;
    logic              rot_zero;
    logic              sign_bit;
    logic [DATA_W-1:0] ext_rev;

    assign amt_zero = (amt_i == '0);
    assign amt_full = (amt_i == FULL_AMT);
    assign amt_over = (amt_i > FULL_AMT);
    assign rot_zero = (amt_i[SH_W-1:0] == '0);
    assign sign_bit = operand_i[DATA_W-1];

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign ext_rev[i] = ext_i[DATA_W-i];
    end

    // Pick the result and carry for the current kind and distance class.
    always_comb begin
        result_o = operand_i;
        carry_o  = carry_i;
        if (!amt_zero) begin
            unique case (kind_i)
                SK_LSL: begin
                    if (amt_over) begin
                        result_o = '0;
                        carry_o  = 1'b0;
                    end else if (amt_full) begin
                        result_o = '0;
                        carry_o  = operand_i[0];
                    end else begin
                        result_o = ext_rev;
                        carry_o  = ext_i[0];
                    end
                end
                SK_LSR: begin
                    if (amt_over) begin
                        result_o = '0;
                        carry_o  = 1'b0;
                    end else if (amt_full) begin
                        result_o = '0;
                        carry_o  = sign_bit;
                    end else begin
                        result_o = ext_i[DATA_W:1];
                        carry_o  = ext_i[0];
                    end
                end
                SK_ASR: begin
                    if (amt_over || amt_full) begin
                        result_o = {DATA_W{sign_bit}};
                        carry_o  = sign_bit;
                    end else begin
                        result_o = ext_i[DATA_W:1];
                        carry_o  = ext_i[0];
                    end
                end
                default: begin
                    if (rot_zero) begin
                        result_o = operand_i;
                        carry_o  = sign_bit;
                    end else begin
                        result_o = rot_i;
                        carry_o  = rot_i[DATA_W-1];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/shift_flags.sv
// Derives the negative and zero flags from the final result.
module shift_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result_i,
    output logic              neg_o,
    output logic              zero_o
);

    // Sign of the result and all-zero detect.
    always_comb begin
        neg_o  = result_i[DATA_W-1];
        zero_o = ~|result_i;
    end

endmodule

// File: rtl/shifter_unit.sv
// Combinational shift unit: logical left/right, arithmetic right and rotate
// right, with the distance taken from a register byte or an immediate field.
// Assumes DATA_W is a power of two below 2**AMT_W. The block has no state;
// the caller stores the flags.
module shifter_unit
    import shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 5
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [AMT_W-1:0]  amt_reg_i,
    input  logic [IMM_W-1:0]  amt_imm_i,
    input  logic              use_imm_i,
    input  logic [1:0]        kind_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              neg_o,
    output logic              zero_o
);

    localparam int SH_W = $clog2(DATA_W);

    logic [AMT_W-1:0]  amt_eff;
    logic [DATA_W-1:0] op_rev;
    logic [DATA_W-1:0] core_din;
    logic              core_fill;
    logic [DATA_W:0]   core_ext;
    logic [DATA_W-1:0] core_rot;

    for (genvar i = 0; i < DATA_W; i++) begin : g_oprev
        assign op_rev[i] = operand_i[DATA_W-1-i];
    end

    // Feed the reversed operand for left shifts so the core only shifts right.
    always_comb begin
        core_din  = (kind_i == SK_LSL) ? op_rev : operand_i;
        core_fill = (kind_i == SK_ASR) && operand_i[DATA_W-1];
    end

    shift_amount_sel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W),
        .IMM_W  (IMM_W)
    ) u_amt (
        .kind_i    (kind_i),
        .use_imm_i (use_imm_i),
        .amt_reg_i (amt_reg_i),
        .amt_imm_i (amt_imm_i),
        .amt_o     (amt_eff)
    );

    shift_stages #(
        .DATA_W (DATA_W)
    ) u_core (
        .din_i  (core_din),
        .fill_i (core_fill),
        .dist_i (amt_eff[SH_W-1:0]),
        .ext_o  (core_ext),
        .rot_o  (core_rot)
    );

    shift_result_mux #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_mux (
        .kind_i    (kind_i),
        .amt_i     (amt_eff),
        .operand_i (operand_i),
        .carry_i   (carry_i),
        .ext_i     (core_ext),
        .rot_i     (core_rot),
        .result_o  (result_o),
        .carry_o   (carry_o)
    );

    shift_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .result_i (result_o),
        .neg_o    (neg_o),
        .zero_o   (zero_o)
    );

endmodule

// File: rtl/shifter_unit_checker.sv
// Property checker for shifter_unit. The block has no clock, so every check is
// an immediate assertion evaluated whenever the inputs or outputs change.
module shifter_unit_checker #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 5
) (
    input logic [DATA_W-1:0] operand_i,
    input logic [AMT_W-1:0]  amt_reg_i,
    input logic [IMM_W-1:0]  amt_imm_i,
    input logic              use_imm_i,
    input logic [1:0]        kind_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o,
    input logic              neg_o,
    input logic              zero_o
);

    logic msb;
    assign msb = operand_i[DATA_W-1];

    // Input/output relations, one group per requirement.
    always_comb begin
        if (!$isunknown({operand_i, amt_reg_i, amt_imm_i, use_imm_i, kind_i, carry_i})) begin
            p_flags_r11: assert (neg_o == result_o[DATA_W-1] && zero_o == (result_o == '0))
                else $error("R11 flag mismatch");
            if (!use_imm_i && amt_reg_i == '0) begin
                p_zero_pass_r1: assert (result_o == operand_i && carry_o == carry_i)
                    else $error("R1 zero distance altered value or carry");
            end
            if (!use_imm_i && kind_i[1] == 1'b0 && int'(amt_reg_i) > DATA_W) begin
                p_logic_over_r6: assert (result_o == '0 && carry_o == 1'b0)
                    else $error("R6 oversized logical shift");
            end
            if (!use_imm_i && kind_i == 2'b10 && int'(amt_reg_i) >= DATA_W) begin
                p_asr_sat_r7: assert (result_o == {DATA_W{msb}} && carry_o == msb)
                    else $error("R7 saturated arithmetic shift");
            end
            if (!use_imm_i && kind_i == 2'b11 && amt_reg_i != '0 && amt_reg_i[4:0] == '0) begin
                p_ror_wrap_r8: assert (result_o == operand_i && carry_o == msb)
                    else $error("R8 rotate by multiple of width");
            end
            if (use_imm_i && amt_imm_i == '0 && kind_i == 2'b01) begin
                p_imm_zero_r10: assert (result_o == '0 && carry_o == msb)
                    else $error("R10 immediate zero right shift");
            end
        end
    end

endmodule

bind shifter_unit shifter_unit_checker #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .IMM_W  (IMM_W)
) u_chk (
    .operand_i (operand_i),
    .amt_reg_i (amt_reg_i),
    .amt_imm_i (amt_imm_i),
    .use_imm_i (use_imm_i),
    .kind_i    (kind_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .neg_o     (neg_o),
    .zero_o    (zero_o)
);

// File: tb/shifter_unit_tb.sv
module shifter_unit_tb;

    logic        clk = 1'b0;
    logic [31:0] operand;
    logic [7:0]  amt_reg;
    logic [4:0]  amt_imm;
    logic        use_imm;
    logic [1:0]  kind;
    logic        carry_in;
    logic [31:0] result;
    logic        carry_out;
    logic        neg;
    logic        zero;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    shifter_unit u_dut (
        .operand_i (operand),
        .amt_reg_i (amt_reg),
        .amt_imm_i (amt_imm),
        .use_imm_i (use_imm),
        .kind_i    (kind),
        .carry_i   (carry_in),
        .result_o  (result),
        .carry_o   (carry_out),
        .neg_o     (neg),
        .zero_o    (zero)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  kind;
        logic        use_imm;
        logic [7:0]  amt;
        logic [4:0]  imm;
        logic        cin;
        logic [31:0] op;
        logic [31:0] exp_res;
        logic        exp_c;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        {4'd2,  2'd0, 1'b0, 8'd1,   5'd0, 1'b0, 32'h8000_0001, 32'h0000_0002, 1'b1}, // R2
        {4'd2,  2'd0, 1'b0, 8'd31,  5'd0, 1'b0, 32'h8000_0001, 32'h8000_0000, 1'b0}, // R2
        {4'd5,  2'd0, 1'b0, 8'd32,  5'd0, 1'b0, 32'h8000_0001, 32'h0000_0000, 1'b1}, // R5
        {4'd6,  2'd0, 1'b0, 8'd33,  5'd0, 1'b1, 32'h8000_0001, 32'h0000_0000, 1'b0}, // R6
        {4'd5,  2'd1, 1'b0, 8'd32,  5'd0, 1'b0, 32'h8000_0001, 32'h0000_0000, 1'b1}, // R5
        {4'd3,  2'd1, 1'b0, 8'd1,   5'd0, 1'b0, 32'h8000_0001, 32'h4000_0000, 1'b1}, // R3
        {4'd7,  2'd2, 1'b0, 8'd200, 5'd0, 1'b0, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1}, // R7
        {4'd4,  2'd2, 1'b0, 8'd4,   5'd0, 1'b1, 32'h8000_0001, 32'hF800_0000, 1'b0}, // R4
        {4'd8,  2'd3, 1'b0, 8'd32,  5'd0, 1'b0, 32'h8000_0001, 32'h8000_0001, 1'b1}, // R8
        {4'd8,  2'd3, 1'b0, 8'd1,   5'd0, 1'b0, 32'h8000_0001, 32'hC000_0000, 1'b1}, // R8
        {4'd10, 2'd1, 1'b1, 8'd0,   5'd0, 1'b0, 32'h8000_0001, 32'h0000_0000, 1'b1}, // R10
        {4'd10, 2'd2, 1'b1, 8'd0,   5'd0, 1'b1, 32'h7000_0000, 32'h0000_0000, 1'b0}, // R10
        {4'd9,  2'd0, 1'b1, 8'd0,   5'd0, 1'b1, 32'h8000_0001, 32'h8000_0001, 1'b1}, // R9
        {4'd9,  2'd3, 1'b1, 8'd0,   5'd0, 1'b0, 32'h8000_0001, 32'h8000_0001, 1'b0}, // R9
        {4'd1,  2'd0, 1'b0, 8'd0,   5'd0, 1'b0, 32'h8000_0001, 32'h8000_0001, 1'b0}, // R1
        {4'd9,  2'd0, 1'b1, 8'd255, 5'd4, 1'b0, 32'h0F00_0001, 32'hF000_0010, 1'b0}  // R9: immediate used, register ignored
    };

    // Behavioural reference built from the requirement text.
    function automatic logic [32:0] ref_shift(input logic [1:0] k, input logic ui,
                                              input logic [7:0] ar, input logic [4:0] ai,
                                              input logic ci, input logic [31:0] op);
        int n;
        logic [63:0] t;
        int r5;
        logic [31:0] rr;
        n = ui ? int'(ai) : int'(ar);
        if (ui && ai == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
        if (n == 0) return {ci, op};
        case (k)
            2'd0: begin
                if (n > 32) return 33'd0;
                t = {32'd0, op} << n;
                return {t[32], t[31:0]};
            end
            2'd1: begin
                if (n > 32) return 33'd0;
                t = {op, 32'd0} >> n;
                return {t[31], t[63:32]};
            end
            2'd2: begin
                if (n >= 32) return {op[31], {32{op[31]}}};
                t = $signed({op, 32'd0}) >>> n;
                return {t[31], t[63:32]};
            end
            default: begin
                r5 = n % 32;
                if (r5 == 0) return {op[31], op};
                rr = (op >> r5) | (op << (32 - r5));
                return {op[r5-1], rr};
            end
        endcase
    endfunction

    function automatic string req_tag(input logic [1:0] k, input int n);
        if (n == 0) return "R1";
        if (k == 2'd3) return "R8";
        if (n < 32) return (k == 2'd0) ? "R2" : (k == 2'd1) ? "R3" : "R4";
        if (k == 2'd2) return "R7";
        return (n == 32) ? "R5" : "R6";
    endfunction

    task automatic apply(input logic [1:0] k, input logic ui, input logic [7:0] ar,
                         input logic [4:0] ai, input logic ci, input logic [31:0] op);
        @(negedge clk);
        kind = k; use_imm = ui; amt_reg = ar; amt_imm = ai; carry_in = ci; operand = op;
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] er, input logic ec);
        checks++;
        if (result !== er || carry_out !== ec) begin
            failures++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, result, carry_out, er, ec);
        end
        checks++;
        if (neg !== er[31] || zero !== (er == 32'd0)) begin
            failures++;
            $display("FAIL R11 (%s): neg=%b zero=%b expected neg=%b zero=%b",
                     tag, neg, zero, er[31], (er == 32'd0));
        end
    endtask

    initial begin
        logic [32:0] exp;
        int amts [6] = '{0, 1, 31, 32, 33, 255};
        logic [31:0] ops [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};

        // Idle state: all-zero inputs give zero result, carry passes, Z set (R1, R11).
        apply(2'd0, 1'b0, 8'd0, 5'd0, 1'b0, 32'd0);
        check("R1", 32'd0, 1'b0);

        // Directed vector table.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].kind, VECS[i].use_imm, VECS[i].amt, VECS[i].imm, VECS[i].cin, VECS[i].op);
            check($sformatf("R%0d", VECS[i].req), VECS[i].exp_res, VECS[i].exp_c);
        end

        // Register-distance sweep over the boundary amounts on every kind (R1-R8 by tag).
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 6; a++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int c = 0; c < 2; c++) begin
                        exp = ref_shift(2'(k), 1'b0, 8'(amts[a]), 5'd0, 1'(c), ops[o]);
                        apply(2'(k), 1'b0, 8'(amts[a]), 5'd0, 1'(c), ops[o]);
                        check(req_tag(2'(k), amts[a]), exp[31:0], exp[32]);
                    end
                end
            end
        end

        // Immediate-distance sweep, register byte held at a misleading value (R9, R10).
        for (int k = 0; k < 4; k++) begin
            for (int im = 0; im < 32; im += 31) begin
                for (int o = 0; o < 4; o++) begin
                    exp = ref_shift(2'(k), 1'b1, 8'd77, 5'(im), 1'b1, ops[o]);
                    apply(2'(k), 1'b1, 8'd77, 5'(im), 1'b1, ops[o]);
                    check((im == 0) ? ((k == 1 || k == 2) ? "R10" : "R9") : "R9",
                          exp[31:0], exp[32]);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule